// File: doc/BRIEF.md
# Request/Acknowledge Word Crossing Between Clock Domains

This block carries one data word at a time from a source clock domain to a destination clock domain whose clock has no fixed relation to the source clock. The source registers the word and holds it unchanged. A single request line is then passed across. The destination takes the word only after its own two-flop synchronizer has resolved that request. It answers on a single acknowledge line, which comes back through a second two-flop synchronizer. No data bit is ever synchronized on its own, so the destination never sees a word in which some bits are new and some are old.

A parameter picks the signalling. In return-to-zero signalling, a transfer is request high, acknowledge high, request low, acknowledge low. In toggle signalling, each transfer is one level change of the request, answered by one level change of the acknowledge. A user on the source side pulses `send_i` while `busy_o` is low. A user on the destination side sees `rx_strobe_o` for one cycle, with the new word on `rx_data_o`. Each domain has its own asynchronous, active-low reset.

Top module: `hs_word_xfer`

## Requirements
- R1: After reset, `busy_o`, `overflow_o` and `rx_strobe_o` are 0 and `rx_data_o` is all zeros.
- R2: A `send_i` sampled while `busy_o` is low loads `send_data_i` and sets `busy_o` from the next source clock edge.
- R3: While `busy_o` is high, the word presented across the domain boundary does not change.
- R4: A `send_i` sampled while `busy_o` is high is ignored: it produces no delivery, it does not alter the word in flight, and it sets `overflow_o`. `overflow_o` stays set until the source reset.
- R5: Every accepted word appears on `rx_data_o` exactly once, in the order of acceptance. Its arrival is marked by `rx_strobe_o` being high for exactly one destination cycle.
- R6: In return-to-zero mode (MODE = HS_FOUR_PHASE), `busy_o` falls only once both the request and the synchronized acknowledge are back at 0. A transfer therefore keeps the source busy for longer than a toggle transfer does.
- R7: In toggle mode (MODE = HS_TWO_PHASE), each transfer inverts the request level once. `busy_o` falls as soon as the synchronized acknowledge equals the request level.
- R8: `rx_data_o` changes only in a cycle in which `rx_strobe_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| send_i | input | 1 | Request to transfer `send_data_i` |
| send_data_i | input | DATA_W | Word to transfer |
| busy_o | output | 1 | A transfer is in flight; new requests are refused |
| overflow_o | output | 1 | Sticky: a request arrived while busy |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| rx_data_o | output | DATA_W | Last word received |
| rx_strobe_o | output | 1 | One-cycle pulse: `rx_data_o` holds a new word |

## Verification
The hardest situation to reach is a request that crosses at a phase where it lands just after a destination edge, with a clock ratio that leaves the handshake no regular rhythm. Four destination clock periods are therefore swept against the fixed source clock. All are non-integer ratios, running from much faster to several times slower than the source. Two instances, one per signalling mode, receive the same word stream. A refused request is injected in the middle of a live transfer, in each sweep.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;
    typedef enum logic {
        HS_FOUR_PHASE = 1'b0,
        HS_TWO_PHASE  = 1'b1
    } hs_mode_e;
endpackage

// File: rtl/hs_sync_bit.sv
module hs_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_d, chain_q;

    always_comb chain_d = {chain_q[TOP-1:0], d_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[TOP];
endmodule

// File: rtl/hs_src_ctrl.sv
module hs_src_ctrl
    import hs_xfer_pkg::*;
#(
    parameter int       DATA_W = 16,
    parameter hs_mode_e MODE   = HS_FOUR_PHASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ack_sync_i,
    output logic              req_o,
    output logic [DATA_W-1:0] data_o,
    output logic              busy_o,
    output logic              overflow_o
);
    typedef struct packed {
        logic              req;
        logic              busy;
        logic              ovf;
        logic [DATA_W-1:0] data;
    } src_state_t;

    src_state_t s_d, s_q;
    logic       accept;

    always_comb begin
        s_d    = s_q;
        accept = send_i && !s_q.busy;
        if (send_i && s_q.busy) s_d.ovf = 1'b1;
        if (accept) begin
            s_d.data = data_i;
            s_d.busy = 1'b1;
            s_d.req  = (MODE == HS_TWO_PHASE) ? ~s_q.req : 1'b1;
        end else if (s_q.busy) begin
            if (MODE == HS_TWO_PHASE) begin
                if (ack_sync_i == s_q.req) s_d.busy = 1'b0;
            end else begin
                if (s_q.req && ack_sync_i)        s_d.req  = 1'b0;
                else if (!s_q.req && !ack_sync_i) s_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_o      = s_q.req;
    assign data_o     = s_q.data;
    assign busy_o     = s_q.busy;
    assign overflow_o = s_q.ovf;

    assert_busy_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (send_i && !busy_o) |=> busy_o);

    assert_hold_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(data_o)));

    assert_sticky_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    generate
        if (MODE == HS_FOUR_PHASE) begin : g_rtz_chk
            assert_rtz_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(busy_o) |-> (!req_o && !ack_sync_i));
        end else begin : g_tgl_chk
            assert_toggle_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(busy_o) |-> (req_o == ack_sync_i));
        end
    endgenerate
endmodule

// File: rtl/hs_dst_ctrl.sv
module hs_dst_ctrl
    import hs_xfer_pkg::*;
#(
    parameter int       DATA_W = 16,
    parameter hs_mode_e MODE   = HS_FOUR_PHASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] data_o,
    output logic              strobe_o
);
    typedef struct packed {
        logic              ack;
        logic              stb;
        logic [DATA_W-1:0] data;
    } dst_state_t;

    dst_state_t s_d, s_q;
    logic       take;

    always_comb begin
        s_d     = s_q;
        take    = (MODE == HS_TWO_PHASE) ? (req_sync_i ^ s_q.ack)
                                         : (req_sync_i & ~s_q.ack);
        s_d.ack = req_sync_i;
        s_d.stb = take;
        if (take) s_d.data = bus_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ack_o    = s_q.ack;
    assign data_o   = s_q.data;
    assign strobe_o = s_q.stb;

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    assert_hold_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |-> $stable(data_o));
endmodule

// File: rtl/hs_word_xfer.sv
module hs_word_xfer
    import hs_xfer_pkg::*;
#(
    parameter int       DATA_W = 16,
    parameter hs_mode_e MODE   = HS_FOUR_PHASE
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              send_i,
    input  logic [DATA_W-1:0] send_data_i,
    output logic              busy_o,
    output logic              overflow_o,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_strobe_o
);
    logic              req, req_s, ack, ack_s;
    logic [DATA_W-1:0] xfer_bus;

    hs_src_ctrl #(.DATA_W(DATA_W), .MODE(MODE)) u_src (
        .clk(src_clk), .rst_n(src_rst_n), .send_i(send_i), .data_i(send_data_i),
        .ack_sync_i(ack_s), .req_o(req), .data_o(xfer_bus),
        .busy_o(busy_o), .overflow_o(overflow_o)
    );

    hs_sync_bit #(.STAGES(2)) u_req_sync (
        .clk(dst_clk), .rst_n(dst_rst_n), .d_i(req), .q_o(req_s)
    );

    hs_dst_ctrl #(.DATA_W(DATA_W), .MODE(MODE)) u_dst (
        .clk(dst_clk), .rst_n(dst_rst_n), .req_sync_i(req_s), .bus_i(xfer_bus),
        .ack_o(ack), .data_o(rx_data_o), .strobe_o(rx_strobe_o)
    );

    hs_sync_bit #(.STAGES(2)) u_ack_sync (
        .clk(src_clk), .rst_n(src_rst_n), .d_i(ack), .q_o(ack_s)
    );
endmodule

// File: tb/hs_word_xfer_test.sv
`timescale 1ns/1ps
module hs_word_xfer_test;
    import hs_xfer_pkg::*;
    localparam int W = 16;

    logic src_clk = 0, dst_clk = 0, src_rst_n = 0, dst_rst_n = 0;
    logic send = 0;
    logic [W-1:0] sdata = '0;
    logic busy4, ovf4, stb4, busy2, ovf2, stb2;
    logic [W-1:0] rx4, rx2;
    realtime dst_half = 3.7;

    int n_chk = 0, n_fail = 0;
    logic [W-1:0] exp_w [0:63];
    int tx_n = 0, rx4_n = 0, rx2_n = 0;
    logic [W-1:0] last4 = '0, last2 = '0;
    bit run_sb = 0;

    always #5 src_clk = ~src_clk;
    always #(dst_half) dst_clk = ~dst_clk;

    hs_word_xfer #(.DATA_W(W), .MODE(HS_FOUR_PHASE)) uut (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .send_i(send), .send_data_i(sdata),
        .busy_o(busy4), .overflow_o(ovf4), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .rx_data_o(rx4), .rx_strobe_o(stb4)
    );

    hs_word_xfer #(.DATA_W(W), .MODE(HS_TWO_PHASE)) uut_tp (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .send_i(send), .send_data_i(sdata),
        .busy_o(busy2), .overflow_o(ovf2), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .rx_data_o(rx2), .rx_strobe_o(stb2)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R5 and R8 scoreboard, sampled between destination edges
    always @(negedge dst_clk) begin
        if (dst_rst_n && run_sb) begin
            if (stb4) begin
                check(rx4_n < tx_n && rx4 == exp_w[rx4_n % 64], "R5 rtz word", rx4, exp_w[rx4_n % 64]);
                last4 = rx4; rx4_n++;
            end else check(rx4 == last4, "R8 rtz hold", rx4, last4);
            if (stb2) begin
                check(rx2_n < tx_n && rx2 == exp_w[rx2_n % 64], "R5 toggle word", rx2, exp_w[rx2_n % 64]);
                last2 = rx2; rx2_n++;
            end else check(rx2 == last2, "R8 toggle hold", rx2, last2);
        end
    end

    task automatic do_reset();
        run_sb = 0;
        src_rst_n = 0; dst_rst_n = 0;
        repeat (3) @(negedge src_clk);
        check({busy4, ovf4, stb4, busy2, ovf2, stb2} == 6'b0, "R1 flags",
              {busy4, ovf4, stb4, busy2, ovf2, stb2}, 0);
        check(rx4 == '0 && rx2 == '0, "R1 data", {rx4, rx2}, 0);
        tx_n = 0; rx4_n = 0; rx2_n = 0; last4 = '0; last2 = '0;
        @(negedge dst_clk); dst_rst_n = 1;
        @(negedge src_clk); src_rst_n = 1;
        run_sb = 1;
        @(negedge src_clk);
    endtask

    task automatic send_word(input logic [W-1:0] w, input bit try_ovf);
        int c4 = 0, c2 = 0;
        while (busy4 || busy2) @(negedge src_clk);
        send = 1; sdata = w; exp_w[tx_n % 64] = w; tx_n++;
        @(negedge src_clk);
        send = 0; sdata = ~w;
        check(busy4 && busy2, "R2 busy", {busy4, busy2}, 2'b11);
        if (try_ovf) begin
            send = 1;
            @(negedge src_clk);
            send = 0;
            check(ovf4 && ovf2, "R4 overflow set", {ovf4, ovf2}, 2'b11);
        end
        while (busy4 || busy2) begin
            if (busy4) c4++;
            if (busy2) c2++;
            @(negedge src_clk);
        end
        check(c4 > c2, "R6 R7 busy span", c4, c2);
    endtask

    initial begin
        repeat (150000) @(posedge src_clk);
        n_chk++; n_fail++;
        $display("FAIL R5: watchdog expired, actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int r = 0; r < 4; r++) begin
            case (r)
                0: dst_half = 3.7;
                1: dst_half = 6.1;
                2: dst_half = 13.3;
                default: dst_half = 27.9;
            endcase
            do_reset();
            for (int k = 0; k < 40; k++) begin
                send_word(W'(k * 40503 + r * 257 + 4660), k == 5);
            end
            repeat (10) @(negedge dst_clk);
            check(rx4_n == tx_n, "R5 rtz count", rx4_n, tx_n);
            check(rx2_n == tx_n, "R5 toggle count", rx2_n, tx_n);
            check(ovf4 && ovf2, "R4 sticky", {ovf4, ovf2}, 2'b11);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule